// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one atomic memory operation at a time for a packet-filter style execution core. The core supplies the effective address, an access size code, an 8-bit operation selector taken from the instruction's immediate, the source register value and the value of register zero. The block reads the memory word, computes the new value, writes it back over a simple request/ready memory port, and returns the old value for write-back to the source register or to register zero.

A lock output is high for the whole read-modify-write, so an external arbiter can keep other masters away from memory between the read and the write. A selector or size the block does not support is reported with an error flag, and memory is not touched.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Size code 2'b00 selects a 32-bit operation and 2'b11 selects a 64-bit operation. Codes 2'b01 and 2'b10 (16-bit and 8-bit) are rejected: `done` and `err` pulse together, and no memory request is made.
- R2: The accepted selectors are 0x00/0x01 add, 0x40/0x41 or, 0x50/0x51 and, 0xa0/0xa1 xor, 0xe1 exchange and 0xf1 compare-exchange. Any other selector, including 0xe0 and 0xf0, is rejected as in R1.
- R3: A simple operation writes `old op src` to the same address. Addition wraps modulo the operation width.
- R4: Selector bit 0 is the fetch flag. On a simple operation with the flag set, `wb_src_en` pulses with `done` and `wb_data` is the old memory value. With the flag clear there is no write-back.
- R5: Exchange (0xe1) writes the source value to memory and returns the old value through `wb_src_en`.
- R6: Compare-exchange (0xf1) writes the source value only when the old value equals the register-zero input. In every case it returns the old value through `wb_r0_en`, never through `wb_src_en`. When the compare fails, no write request is made.
- R7: In 32-bit mode only the low 32 bits of the operands are used. `mem_wide` is low and the upper half of `mem_wdata` is zero. Returned values are zero-extended to 64 bits.
- R8: The read always comes before the write. A request, with its address and direction, is held until `mem_ready`. `lock` is high from the start of the read until the write is accepted, and is low whenever the block is idle.
- R9: `done` is a single-cycle pulse. Write-back enables and `err` are only ever high together with `done`, and the two write-back enables are never high together.
- R10: A `start` that arrives while an operation is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| addr_in | input | AW | Effective address |
| size_code | input | 2 | 00 = 32-bit, 11 = 64-bit, others rejected |
| op_sel | input | 8 | Operation selector from the immediate |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | Register-zero value used as the compare operand |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | Access is 64-bit (else low 32 bits) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts or completes the request |
| lock | output | 1 | Held high for the whole read-modify-write |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Operation rejected, valid with done |
| wb_src_en | output | 1 | Write wb_data to the source register |
| wb_r0_en | output | 1 | Write wb_data to register zero |
| wb_data | output | 64 | Old memory value, zero-extended in 32-bit mode |

## Verification
The assertions check the handshake and framing on every cycle: lock covering every request, requests held stable until ready, the single-cycle done with write-back and error confined to it, exclusive write-back targets, zero upper halves in 32-bit mode, and the absence of memory traffic after a rejected start or a failed compare. Only the bench scenarios can show the arithmetic results, the final memory contents, which operations fetch, the compare outcome for matching and mismatching values, and that a start arriving mid-operation leaves the result unchanged.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned HALF_W = WORD_W / 2;

  localparam logic [1:0] SZ_W32 = 2'b00;
  localparam logic [1:0] SZ_W64 = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_CALC, ST_WR, ST_DONE
  } rmw_state_e;

  typedef enum logic [2:0] {
    K_ADD, K_OR, K_AND, K_XOR, K_XCHG, K_CAS
  } rmw_kind_e;

  // Clear the upper half when the operation is 32 bits wide.
  function automatic logic [WORD_W-1:0] fit_width(logic [WORD_W-1:0] v, logic narrow);
    fit_width = narrow ? {{HALF_W{1'b0}}, v[HALF_W-1:0]} : v;
  endfunction

  function automatic logic [WORD_W-1:0] combine(rmw_kind_e k, logic [WORD_W-1:0] a,
                                                logic [WORD_W-1:0] b);
    case (k)
      K_ADD:   combine = a + b;
      K_OR:    combine = a | b;
      K_AND:   combine = a & b;
      K_XOR:   combine = a ^ b;
      default: combine = b;
    endcase
  endfunction
endpackage

// File: rtl/atomic_rmw_decode.sv
module atomic_rmw_decode
  import atomic_rmw_pkg::*;
(
  input  logic [7:0] sel_i,
  input  logic [1:0] size_i,
  output rmw_kind_e  kind_o,
  output logic       fetch_o,
  output logic       valid_o
);
  logic sel_ok;
  logic size_ok;

  always_comb begin
    kind_o  = K_ADD;
    fetch_o = sel_i[0];
    sel_ok  = 1'b1;
    case (sel_i[7:1])
      7'h00:   kind_o = K_ADD;
      7'h20:   kind_o = K_OR;
      7'h28:   kind_o = K_AND;
      7'h50:   kind_o = K_XOR;
      7'h70: begin kind_o = K_XCHG; sel_ok = sel_i[0]; end
      7'h78: begin kind_o = K_CAS;  sel_ok = sel_i[0]; end
      default: sel_ok = 1'b0;
    endcase
  end

  assign size_ok = (size_i == SZ_W32) || (size_i == SZ_W64);
  assign valid_o = sel_ok && size_ok;
endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
  import atomic_rmw_pkg::*;
(
  input  rmw_kind_e         kind_i,
  input  logic              narrow_i,
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] src_i,
  input  logic [WORD_W-1:0] cmp_i,
  output logic [WORD_W-1:0] new_o,
  output logic              match_o
);
  logic [WORD_W-1:0] src_f;
  logic [WORD_W-1:0] cmp_f;
  logic [WORD_W-1:0] old_f;

  assign src_f   = fit_width(src_i, narrow_i);
  assign cmp_f   = fit_width(cmp_i, narrow_i);
  assign old_f   = fit_width(old_i, narrow_i);
  assign new_o   = fit_width(combine(kind_i, old_f, src_f), narrow_i);
  assign match_o = (old_f == cmp_f);
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     addr_in,
  input  logic [1:0]        size_code,
  input  logic [7:0]        op_sel,
  input  logic [WORD_W-1:0] src_val,
  input  logic [WORD_W-1:0] r0_val,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              lock,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              wb_src_en,
  output logic              wb_r0_en,
  output logic [WORD_W-1:0] wb_data
);
  rmw_state_e        state;
  rmw_kind_e         dec_kind, kind_q;
  logic              dec_fetch, dec_valid;
  logic              fetch_q, narrow_q, err_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] src_q, r0_q, old_q, new_q, alu_new;
  logic              alu_match;

  // Named events for the checker
  logic start_take, start_bad, cas_fail;

  atomic_rmw_decode u_dec (
    .sel_i(op_sel), .size_i(size_code),
    .kind_o(dec_kind), .fetch_o(dec_fetch), .valid_o(dec_valid)
  );

  atomic_rmw_alu u_alu (
    .kind_i(kind_q), .narrow_i(narrow_q), .old_i(old_q),
    .src_i(src_q), .cmp_i(r0_q), .new_o(alu_new), .match_o(alu_match)
  );

  assign start_take = start && (state == ST_IDLE);
  assign start_bad  = start_take && !dec_valid;
  assign cas_fail   = (state == ST_CALC) && (kind_q == K_CAS) && !alu_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind_q   <= K_ADD;
      fetch_q  <= 1'b0;
      narrow_q <= 1'b0;
      err_q    <= 1'b0;
      addr_q   <= '0;
      src_q    <= '0;
      r0_q     <= '0;
      old_q    <= '0;
      new_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_take) begin
          kind_q   <= dec_kind;
          fetch_q  <= dec_fetch;
          narrow_q <= (size_code == SZ_W32);
          addr_q   <= addr_in;
          src_q    <= src_val;
          r0_q     <= r0_val;
          err_q    <= !dec_valid;
          old_q    <= '0;
          state    <= dec_valid ? ST_RD : ST_DONE;
        end
        ST_RD: if (mem_ready) begin
          old_q <= fit_width(mem_rdata, narrow_q);
          state <= ST_CALC;
        end
        ST_CALC: begin
          new_q <= alu_new;
          state <= cas_fail ? ST_DONE : ST_WR;
        end
        ST_WR:   if (mem_ready) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_wide  = !narrow_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;
  assign lock      = (state == ST_RD) || (state == ST_CALC) || (state == ST_WR);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign err       = done && err_q;
  assign wb_src_en = done && !err_q && fetch_q && (kind_q != K_CAS);
  assign wb_r0_en  = done && !err_q && (kind_q == K_CAS);
  assign wb_data   = old_q;
endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker
  import atomic_rmw_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [AW-1:0]     mem_addr,
  input logic              lock,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              wb_src_en,
  input logic              wb_r0_en,
  input logic [WORD_W-1:0] wb_data,
  input logic              start_bad,
  input logic              cas_fail,
  input logic              narrow_q
);
  AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> lock); // R8
  AST_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !lock); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8
  AST_REJECT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> done && err && !mem_req); // R1
  AST_CAS_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cas_fail |=> done && !mem_req); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_src_en || wb_r0_en || err) |-> done); // R9
  AST_WB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_src_en && wb_r0_en)); // R9
  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_src_en || wb_r0_en) && narrow_q |-> wb_data[WORD_W-1:HALF_W] == '0); // R7
endmodule

bind atomic_rmw_unit atomic_rmw_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .lock(lock), .busy(busy),
  .done(done), .err(err), .wb_src_en(wb_src_en), .wb_r0_en(wb_r0_en),
  .wb_data(wb_data), .start_bad(start_bad), .cas_fail(cas_fail),
  .narrow_q(narrow_q)
);

// File: tb/atomic_rmw_unit_bench.sv
`timescale 1ns/1ps
module atomic_rmw_unit_bench;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [1:0]  size_code = 2'b11;
  logic [7:0]  op_sel = 8'h00;
  logic [63:0] src_val = '0, r0_val = '0;
  logic        mem_req, mem_we, mem_wide;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        lock, busy, done, err, wb_src_en, wb_r0_en;
  logic [63:0] wb_data;

  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0, lock_bad = 0, wait_ct = 0;
  logic [63:0] mem_m [int];

  always #2 clk = ~clk;

  atomic_rmw_unit #(.AW(AW)) u_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
    .size_code(size_code), .op_sel(op_sel), .src_val(src_val), .r0_val(r0_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .lock(lock), .busy(busy), .done(done), .err(err),
    .wb_src_en(wb_src_en), .wb_r0_en(wb_r0_en), .wb_data(wb_data)
  );

  // Behavioural memory: decides ready for the coming edge, applies the transfer.
  always @(negedge clk) begin
    if (mem_req && !lock) lock_bad++;
    if (mem_req) begin
      if (wait_ct == 0) begin
        mem_ready = 1'b1;
        mem_rdata = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 64'h0;
        if (mem_we) begin
          if (mem_wide) mem_m[int'(mem_addr)] = mem_wdata;
          else mem_m[int'(mem_addr)] = {mem_rdata[63:32], mem_wdata[31:0]};
          wr_cnt++;
        end else rd_cnt++;
        wait_ct = $urandom_range(0, 2);
      end else begin
        mem_ready = 1'b0;
        wait_ct--;
      end
    end else mem_ready = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] sz, input logic [7:0] sel, input int a,
                        input logic [63:0] s, input logic [63:0] r, input bit poke,
                        input string req);
    logic [63:0] pre, oldv, sf, rf, res, post;
    bit valid, narrow, wr_exp, src_exp, r0_exp;
    int wr0, rd0, n;
    pre    = mem_m.exists(a) ? mem_m[a] : 64'h0;
    valid  = (sz == 2'b00 || sz == 2'b11) &&
             (sel inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'ha0, 8'ha1, 8'he1, 8'hf1});
    narrow = (sz == 2'b00);
    oldv   = narrow ? {32'h0, pre[31:0]} : pre;
    sf     = narrow ? {32'h0, s[31:0]} : s;
    rf     = narrow ? {32'h0, r[31:0]} : r;
    case (sel & 8'hfe)
      8'h00: res = oldv + sf;
      8'h40: res = oldv | sf;
      8'h50: res = oldv & sf;
      8'ha0: res = oldv ^ sf;
      default: res = sf;
    endcase
    wr_exp  = valid && !(sel == 8'hf1 && oldv != rf);
    post    = !wr_exp ? pre : (narrow ? {pre[63:32], res[31:0]} : res);
    src_exp = valid && sel[0] && sel != 8'hf1;
    r0_exp  = valid && sel == 8'hf1;
    wr0 = wr_cnt; rd0 = rd_cnt;
    @(negedge clk);
    start = 1'b1; size_code = sz; op_sel = sel; addr_in = AW'(a); src_val = s; r0_val = r;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: a second start mid-operation must be ignored
      start = 1'b1; op_sel = 8'ha1; src_val = 64'h5a5a; size_code = 2'b11;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(done === 1'b1, {req, " done"}, {63'h0, done}, 64'h1);
    chk(err === !valid, {req, " err"}, {63'h0, err}, {63'h0, !valid});
    chk(wb_src_en === src_exp, {req, " wb_src_en"}, {63'h0, wb_src_en}, {63'h0, src_exp});
    chk(wb_r0_en === r0_exp, {req, " wb_r0_en"}, {63'h0, wb_r0_en}, {63'h0, r0_exp});
    if (src_exp || r0_exp) chk(wb_data === oldv, {req, " wb_data"}, wb_data, oldv);
    chk((wr_cnt - wr0) == (wr_exp ? 1 : 0), {req, " write count"}, 64'(wr_cnt - wr0), {63'h0, wr_exp});
    chk((rd_cnt - rd0) == (valid ? 1 : 0), {req, " read count"}, 64'(rd_cnt - rd0), {63'h0, valid});
    chk((mem_m.exists(a) ? mem_m[a] : 64'h0) === post, {req, " memory"},
        mem_m.exists(a) ? mem_m[a] : 64'h0, post);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {req, " done pulse R9"}, {62'h0, done, busy}, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(lock === 1'b0 && mem_req === 1'b0 && done === 1'b0 && busy === 1'b0,
        "R8 reset idle", {60'h0, lock, mem_req, done, busy}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    mem_m[16] = 64'hffff_ffff_ffff_ffff;
    mem_m[17] = 64'h0f0f_0000_1234_0000;
    mem_m[18] = 64'hdead_beef_ffff_00f0;
    mem_m[19] = 64'h1111_2222_3333_4444;
    mem_m[20] = 64'h0000_0000_0000_0099;
    mem_m[21] = 64'hcafe_0000_8000_0001;
    run_op(2'b11, 8'h00, 16, 64'h2, 64'h0, 0, "R3 R4 add64 wrap no fetch");
    run_op(2'b11, 8'h41, 17, 64'h00f0_0000_0000_000f, 64'h0, 0, "R4 or64 fetch");
    run_op(2'b00, 8'h51, 18, 64'h7777_7777_0f0f_0ff0, 64'h0, 0, "R7 and32 fetch");
    run_op(2'b00, 8'ha0, 18, 64'hffff_ffff_ffff_ffff, 64'h0, 0, "R7 xor32");
    run_op(2'b00, 8'h01, 16, 64'h0000_0000_ffff_ffff, 64'h0, 0, "R3 R7 add32 wrap");
    run_op(2'b11, 8'he1, 19, 64'haaaa_bbbb_cccc_dddd, 64'h0, 0, "R5 xchg64");
    run_op(2'b11, 8'hf1, 20, 64'h0000_0000_0000_0042, 64'h99, 0, "R6 cas64 match");
    run_op(2'b11, 8'hf1, 20, 64'h0000_0000_0000_0077, 64'h99, 0, "R6 cas64 miss");
    run_op(2'b00, 8'hf1, 21, 64'h1234_5678_0000_0005, 64'hffff_ffff_8000_0001, 0, "R6 R7 cas32 match");
    run_op(2'b11, 8'h10, 19, 64'h1, 64'h0, 0, "R2 bad selector");
    run_op(2'b11, 8'he0, 19, 64'h1, 64'h0, 0, "R2 xchg without fetch");
    run_op(2'b11, 8'hf0, 20, 64'h1, 64'h0, 0, "R2 cas without fetch");
    run_op(2'b01, 8'h00, 19, 64'h1, 64'h0, 0, "R1 16-bit size");
    run_op(2'b10, 8'h41, 19, 64'h1, 64'h0, 0, "R1 8-bit size");
    run_op(2'b11, 8'h51, 17, 64'hffff_0000_ffff_ffff, 64'h0, 1, "R10 start while busy");
    chk(lock_bad == 0, "R8 lock over requests", 64'(lock_bad), 64'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule